// File: doc/BRIEF.md
# Column-wise sub-warp packing unit

This block breaks one large warp into a stream of SIMD-width sub-warps. The large warp's active mask arrives as a K-row by N-column bit array with one column per SIMD lane. The block keeps its own working copy of that mask. Every cycle it searches all columns at once and takes at most one ready thread from each column. The chosen threads form one sub-warp, which can mix threads from different rows. For every lane the sub-warp gives a valid bit and the row index of the chosen thread, so that per-lane register bank addresses can be built further down the pipe.

Fetch sees a stall flag while threads remain to be packed. A done pulse marks the cycle that emits the last sub-warp, and in that same cycle fetch may present the next large warp. An unconditional jump needs only one PC update, so it is packed into a single sub-warp in one cycle. A per-thread in-flight bit, kept for every warp slot, holds back a thread whose earlier sub-warp has not yet reported completion.

Top module: `subwarp_packer`

## Requirements
- R1: Bit `r*LANES + c` of `mask_i` is the thread in row `r` and column (lane) `c`. That is thread number `t` with row `t/LANES` and column `t mod LANES`.
- R2: In each packing cycle, each lane picks the lowest-numbered row of its column that is still set in the working copy and is not in flight. `lane_vld_o[c]` is high when lane c found such a row, and `lane_row_o[c*ROW_W +: ROW_W]` holds that row. Both are zero for a lane with no pick and whenever the block is idle.
- R3: A picked thread is cleared from the working copy, so no thread is emitted twice for one load. When no thread is in flight, a load emits exactly as many sub-warps as the largest number of set bits in any one column.
- R4: `stall_o` is high in a packing cycle when bits remain in the working copy after that cycle's pick. Otherwise it is low.
- R5: `done_o` is high for exactly the packing cycle after which no bit remains. A load with an all-zero mask gives one cycle with `done_o` high and `sw_valid_o` low.
- R6: `load_i` is accepted only when `stall_o` is low, including the cycle of `done_o`. A load presented while `stall_o` is high has no effect on the current warp or its sub-warps.
- R7: The mask is captured at an accepted load. Changes on `mask_i` afterwards do not alter the sub-warps of the warp being packed.
- R8: A load with `jump_i` high produces exactly one sub-warp (`sw_valid_o` high) and `done_o` in the first cycle after the load. Its lanes show the lowest set row of each column, in-flight bits are ignored, and no thread is marked in flight.
- R9: Each emitted thread is marked in flight for its warp ID until a completion names the same warp, lane and row. While in flight it is not picked. A cycle with no eligible thread emits no sub-warp, and `stall_o` stays high.
- R10: A completion presented at a clock edge makes the thread eligible from the next cycle. Completion of a thread that is not in flight changes nothing.
- R11: While reset is active, and afterwards until a load is accepted, `sw_valid_o`, `lane_vld_o`, `lane_row_o`, `stall_o` and `done_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Start packing a large warp |
| jump_i | input | 1 | The loaded instruction is an unconditional jump |
| warp_id_i | input | WID_W | ID of the large warp being loaded |
| mask_i | input | ROWS*LANES | Active mask of the large warp, row-major |
| cmpl_valid_i | input | 1 | A sub-warp completion is reported |
| cmpl_warp_i | input | WID_W | Warp ID of the completed sub-warp |
| cmpl_lane_i | input | LANES | Lanes that carried a thread in the completed sub-warp |
| cmpl_row_i | input | LANES*ROW_W | Row index per lane of the completed sub-warp |
| sw_valid_o | output | 1 | A sub-warp is emitted this cycle |
| sw_warp_o | output | WID_W | Warp ID of the emitted sub-warp |
| lane_vld_o | output | LANES | Per-lane thread valid |
| lane_row_o | output | LANES*ROW_W | Per-lane selected row |
| stall_o | output | 1 | Threads remain; fetch must hold |
| done_o | output | 1 | Last sub-warp of the large warp is emitted this cycle |

## Verification
The checker module watches the handshake on every cycle. It checks that a lane is never valid without a sub-warp, that stall and done never coincide, that a load presented under stall leaves the warp unchanged, that an accepted jump finishes in the next cycle, and that the block goes quiet after done unless reloaded. Other behaviour holds only over a scenario and is left to the bench's lockstep model: the lowest-row choice per column, the sub-warp count equal to the fullest column, the in-flight hold across a reload of the same warp, release by completion one cycle later, and the capture of the mask at load.

// File: rtl/swp_pkg.sv
package swp_pkg;

  // Width of an index able to address n items (at least one bit).
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Packing mode of the unit.
  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_PACK = 2'd1,
    PK_JUMP = 2'd2
  } pk_mode_e;

endpackage

// File: rtl/swp_column_pick.sv
// Fixed-priority search of one mask column: lowest set row wins.
module swp_column_pick #(
  parameter int unsigned ROWS  = 8,
  parameter int unsigned ROW_W = 3
) (
  input  logic [ROWS-1:0]  cand_i,
  output logic             hit_o,
  output logic [ROW_W-1:0] row_o,
  output logic [ROWS-1:0]  take_o
);

  always_comb begin
    hit_o  = 1'b0;
    row_o  = '0;
    take_o = '0;
    // Walk downward so the last assignment is the lowest candidate.
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (cand_i[r]) begin
        hit_o     = 1'b1;
        row_o     = ROW_W'(r);
        take_o    = '0;
        take_o[r] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/swp_inflight.sv
// One in-flight bit per thread for every warp slot.
module swp_inflight #(
  parameter int unsigned LANES = 4,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned WARPS = 4,
  parameter int unsigned WID_W = 2,
  parameter int unsigned ROW_W = 3,
  localparam int unsigned CELLS = ROWS * LANES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WID_W-1:0]       rd_warp_i,
  output logic [CELLS-1:0]       rd_bits_o,
  input  logic                   set_en_i,
  input  logic [WID_W-1:0]       set_warp_i,
  input  logic [CELLS-1:0]       set_bits_i,
  input  logic                   clr_en_i,
  input  logic [WID_W-1:0]       clr_warp_i,
  input  logic [LANES-1:0]       clr_lane_i,
  input  logic [LANES*ROW_W-1:0] clr_row_i
);

  logic [CELLS-1:0] flag_q   [WARPS];
  logic [CELLS-1:0] flag_d   [WARPS];
  logic [WARPS-1:0] flag_en;
  logic [CELLS-1:0] clr_bits;

  // Decode the completion's lane/row pairs into a cell vector.
  always_comb begin
    clr_bits = '0;
    for (int c = 0; c < LANES; c++) begin
      if (clr_lane_i[c] && (int'(clr_row_i[c*ROW_W +: ROW_W]) < ROWS)) begin
        clr_bits[int'(clr_row_i[c*ROW_W +: ROW_W]) * LANES + c] = 1'b1;
      end
    end
  end

  for (genvar w = 0; w < WARPS; w++) begin : g_slot
    logic hit_set;
    logic hit_clr;

    always_comb begin
      hit_set    = set_en_i && (set_warp_i == WID_W'(w));
      hit_clr    = clr_en_i && (clr_warp_i == WID_W'(w));
      flag_en[w] = hit_set || hit_clr;
      flag_d[w]  = flag_q[w];
      if (hit_clr) flag_d[w] = flag_d[w] & ~clr_bits;
      if (hit_set) flag_d[w] = flag_d[w] | set_bits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[w] <= '0;
      end else if (flag_en[w]) begin
        flag_q[w] <= flag_d[w];
      end
    end
  end

  always_comb begin
    rd_bits_o = '0;
    for (int w = 0; w < WARPS; w++) begin
      if (rd_warp_i == WID_W'(w)) rd_bits_o = flag_q[w];
    end
  end

endmodule

// File: rtl/subwarp_packer.sv
module subwarp_packer #(
  parameter int unsigned LANES = 4,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned WARPS = 4,
  localparam int unsigned CELLS = ROWS * LANES,
  localparam int unsigned ROW_W = swp_pkg::idx_w(ROWS),
  localparam int unsigned WID_W = swp_pkg::idx_w(WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   jump_i,
  input  logic [WID_W-1:0]       warp_id_i,
  input  logic [CELLS-1:0]       mask_i,
  input  logic                   cmpl_valid_i,
  input  logic [WID_W-1:0]       cmpl_warp_i,
  input  logic [LANES-1:0]       cmpl_lane_i,
  input  logic [LANES*ROW_W-1:0] cmpl_row_i,
  output logic                   sw_valid_o,
  output logic [WID_W-1:0]       sw_warp_o,
  output logic [LANES-1:0]       lane_vld_o,
  output logic [LANES*ROW_W-1:0] lane_row_o,
  output logic                   stall_o,
  output logic                   done_o
);

  import swp_pkg::*;

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rs_n = rst_sync_q[1];

  // State
  pk_mode_e         mode_q, mode_d;
  logic [CELLS-1:0] work_q, work_d;
  logic [WID_W-1:0] warp_q, warp_d;
  logic             state_en;

  // Pick datapath
  logic [CELLS-1:0]       infl_bits;
  logic [CELLS-1:0]       elig;
  logic [CELLS-1:0]       pick_bits;
  logic [LANES-1:0]       hit;
  logic [LANES*ROW_W-1:0] row_sel;
  logic [CELLS-1:0]       rem;
  logic                   in_pack;
  logic                   is_jump;
  logic                   accept;
  logic                   set_en;

  assign in_pack = (mode_q != PK_IDLE);
  assign is_jump = (mode_q == PK_JUMP);
  // A jump only updates the PC, so it ignores the interlock.
  assign elig    = is_jump ? work_q : (work_q & ~infl_bits);

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic [ROWS-1:0] cand;
    logic [ROWS-1:0] take;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign cand[r]               = elig[r*LANES + c];
      assign pick_bits[r*LANES + c] = take[r];
    end

    swp_column_pick #(
      .ROWS  (ROWS),
      .ROW_W (ROW_W)
    ) u_pick (
      .cand_i (cand),
      .hit_o  (hit[c]),
      .row_o  (row_sel[c*ROW_W +: ROW_W]),
      .take_o (take)
    );
  end

  assign rem = is_jump ? '0 : (work_q & ~pick_bits);

  // Outputs
  assign stall_o    = in_pack && (|rem);
  assign done_o     = in_pack && !(|rem);
  assign sw_valid_o = is_jump || ((mode_q == PK_PACK) && (|hit));
  assign sw_warp_o  = warp_q;
  assign lane_vld_o = in_pack ? hit : '0;
  assign lane_row_o = in_pack ? row_sel : '0;

  assign accept   = load_i && !stall_o;
  assign state_en = accept || in_pack;

  // Next state
  always_comb begin
    mode_d = mode_q;
    work_d = work_q;
    warp_d = warp_q;
    if (accept) begin
      mode_d = jump_i ? PK_JUMP : PK_PACK;
      work_d = mask_i;
      warp_d = warp_id_i;
    end else if (in_pack) begin
      work_d = rem;
      if (!(|rem)) mode_d = PK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      mode_q <= PK_IDLE;
      work_q <= '0;
      warp_q <= '0;
    end else if (state_en) begin
      mode_q <= mode_d;
      work_q <= work_d;
      warp_q <= warp_d;
    end
  end

  // In-flight interlock
  assign set_en = (mode_q == PK_PACK) && (|hit);

  swp_inflight #(
    .LANES (LANES),
    .ROWS  (ROWS),
    .WARPS (WARPS),
    .WID_W (WID_W),
    .ROW_W (ROW_W)
  ) u_infl (
    .clk        (clk),
    .rst_n      (rs_n),
    .rd_warp_i  (warp_q),
    .rd_bits_o  (infl_bits),
    .set_en_i   (set_en),
    .set_warp_i (warp_q),
    .set_bits_i (pick_bits),
    .clr_en_i   (cmpl_valid_i),
    .clr_warp_i (cmpl_warp_i),
    .clr_lane_i (cmpl_lane_i),
    .clr_row_i  (cmpl_row_i)
  );

endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WID_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic             jump_i,
  input logic             sw_valid_o,
  input logic [WID_W-1:0] sw_warp_o,
  input logic [LANES-1:0] lane_vld_o,
  input logic             stall_o,
  input logic             done_o
);

  // R2: a lane is never valid outside an emitted sub-warp
  p_lane_in_sw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_vld_o) |-> sw_valid_o);

  // R4 and R5: stall and done are exclusive
  p_stall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall_o && done_o));

  // R6: load under stall leaves the warp in place
  p_load_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && load_i) |=> ($stable(sw_warp_o) && (stall_o || done_o)));

  // R8: an accepted jump finishes with one sub-warp in the next cycle
  p_jump_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && jump_i && !stall_o) |=> (done_o && sw_valid_o));

  // R5: after done and no reload the unit is quiet
  p_quiet_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (!sw_valid_o && !stall_o && !done_o));

endmodule

bind subwarp_packer swp_checker #(
  .LANES (LANES),
  .WID_W (WID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .jump_i     (jump_i),
  .sw_valid_o (sw_valid_o),
  .sw_warp_o  (sw_warp_o),
  .lane_vld_o (lane_vld_o),
  .stall_o    (stall_o),
  .done_o     (done_o)
);

// File: tb/subwarp_packer_test.sv
module subwarp_packer_test;

  localparam int L  = 4;
  localparam int K  = 8;
  localparam int NC = L * K;
  localparam int RW = 3;
  localparam int WW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic           load_i, jump_i, cmpl_valid_i;
  logic [WW-1:0]  warp_id_i, cmpl_warp_i;
  logic [NC-1:0]  mask_i;
  logic [L-1:0]   cmpl_lane_i;
  logic [L*RW-1:0] cmpl_row_i;
  logic           sw_valid_o, stall_o, done_o;
  logic [WW-1:0]  sw_warp_o;
  logic [L-1:0]   lane_vld_o;
  logic [L*RW-1:0] lane_row_o;

  subwarp_packer uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .jump_i(jump_i),
    .warp_id_i(warp_id_i), .mask_i(mask_i), .cmpl_valid_i(cmpl_valid_i),
    .cmpl_warp_i(cmpl_warp_i), .cmpl_lane_i(cmpl_lane_i), .cmpl_row_i(cmpl_row_i),
    .sw_valid_o(sw_valid_o), .sw_warp_o(sw_warp_o), .lane_vld_o(lane_vld_o),
    .lane_row_o(lane_row_o), .stall_o(stall_o), .done_o(done_o)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int n_sub = 0;
  int n_done = 0;

  // Bench model state
  bit          m_active, m_jump;
  int          m_warp;
  logic [NC-1:0] m_mask;
  logic [NC-1:0] m_infl [4];

  task automatic check(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic void model_pick(input logic [NC-1:0] work, input logic [NC-1:0] infl,
                                     input bit jmp, output logic [NC-1:0] take,
                                     output logic [L-1:0] vld, output logic [L*RW-1:0] rows);
    take = '0; vld = '0; rows = '0;
    for (int c = 0; c < L; c++)
      for (int r = 0; r < K; r++)
        if (!vld[c] && work[r*L+c] && (jmp || !infl[r*L+c])) begin
          vld[c] = 1'b1;
          rows[c*RW +: RW] = RW'(r);
          take[r*L+c] = 1'b1;
        end
  endfunction

  function automatic bit model_stall();
    logic [NC-1:0] tk; logic [L-1:0] v; logic [L*RW-1:0] rw;
    model_pick(m_mask, m_infl[m_warp], m_jump, tk, v, rw);
    return m_active && !m_jump && ((m_mask & ~tk) != '0);
  endfunction

  function automatic int max_col(input logic [NC-1:0] m);
    int best = 0;
    for (int c = 0; c < L; c++) begin
      int n = 0;
      for (int r = 0; r < K; r++) if (m[r*L+c]) n++;
      if (n > best) best = n;
    end
    return best;
  endfunction

  // Compare one cycle against the model, then advance one clock.
  task automatic cycle(input string tag);
    logic [NC-1:0] tk, rem; logic [L-1:0] v; logic [L*RW-1:0] rw;
    bit e_sv, e_st, e_dn;
    logic [31:0] ex, ac;
    model_pick(m_mask, m_infl[m_warp], m_jump, tk, v, rw);
    rem  = m_jump ? '0 : (m_mask & ~tk);
    e_st = m_active && (rem != '0);
    e_dn = m_active && (rem == '0);
    e_sv = m_active && (m_jump || (v != '0));
    if (!m_active) begin v = '0; rw = '0; end
    ex = {13'd0, e_sv, e_dn, e_st, v, rw};
    ac = {13'd0, sw_valid_o, done_o, stall_o, lane_vld_o, lane_row_o};
    check(ac == ex && (!e_sv || sw_warp_o == WW'(m_warp)), tag, ac, ex);
    if (sw_valid_o) n_sub++;
    if (done_o) n_done++;
    @(posedge clk);
    // Model update: clear completions, then mark new picks
    if (cmpl_valid_i)
      for (int c = 0; c < L; c++)
        if (cmpl_lane_i[c]) m_infl[cmpl_warp_i][int'(cmpl_row_i[c*RW +: RW])*L + c] = 1'b0;
    if (m_active) begin
      if (!m_jump) m_infl[m_warp] = m_infl[m_warp] | tk;
      m_mask = rem;
      if (rem == '0) m_active = 0;
    end
    if (load_i && !e_st) begin
      m_active = 1; m_jump = jump_i; m_warp = int'(warp_id_i); m_mask = mask_i;
    end
    @(negedge clk);
    load_i = 0; cmpl_valid_i = 0; cmpl_lane_i = '0;
  endtask

  task automatic load(input int w, input logic [NC-1:0] m, input bit j);
    load_i = 1; warp_id_i = WW'(w); mask_i = m; jump_i = j;
  endtask

  // Complete the lowest in-flight row per lane of warp w (random lanes if rnd).
  task automatic complete(input int w, input bit rnd);
    cmpl_valid_i = 1; cmpl_warp_i = WW'(w); cmpl_lane_i = '0; cmpl_row_i = '0;
    for (int c = 0; c < L; c++)
      for (int r = K - 1; r >= 0; r--)
        if (m_infl[w][r*L+c] && (!rnd || $urandom_range(1, 0) == 1)) begin
          cmpl_lane_i[c] = 1'b1;
          cmpl_row_i[c*RW +: RW] = RW'(r);
        end
  endtask

  task automatic drain(input string tag, input bit with_cmpl);
    for (int i = 0; i < 200 && m_active; i++) begin
      if (with_cmpl) complete(m_warp, 1'b1);
      cycle(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] ma;
    void'($urandom(32'h5eed_0042));
    rst_n = 0; load_i = 0; jump_i = 0; warp_id_i = '0; mask_i = '0;
    cmpl_valid_i = 0; cmpl_warp_i = '0; cmpl_lane_i = '0; cmpl_row_i = '0;
    m_active = 0; m_jump = 0; m_warp = 0; m_mask = '0;
    for (int w = 0; w < 4; w++) m_infl[w] = '0;
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    check({sw_valid_o, stall_o, done_o, lane_vld_o, lane_row_o} == '0, "R11 in reset",
          {13'd0, sw_valid_o, stall_o, done_o, lane_vld_o, lane_row_o}, 32'd0);
    rst_n = 1;
    repeat (4) cycle("R11 after reset");

    // R1: single thread 13 = row 3, column 1
    load(0, 32'h0000_2000, 0);
    cycle("R1 load");
    check(lane_vld_o == 4'b0010 && lane_row_o[1*RW +: RW] == 3'd3, "R1 thread position",
          {24'd0, lane_vld_o, 1'b0, lane_row_o[RW +: RW]}, {24'd0, 4'b0010, 1'b0, 3'd3});
    drain("R1/R5 drain", 0);
    complete(0, 0); cycle("R10 clear warp0");

    // R2/R3/R4: divergent mask, fullest column defines count
    ma = 32'hF0F1_3A5C;
    n_sub = 0; n_done = 0;
    load(1, ma, 0);
    cycle("R2/R4 load");
    // R7: mask input changes during packing have no effect
    mask_i = 32'hFFFF_FFFF;
    drain("R2/R4/R7 pack", 0);
    check(n_sub == max_col(ma), "R3 sub-warp count", n_sub, max_col(ma));
    check(n_done == 1, "R5 one done pulse", n_done, 1);

    // R5: empty mask gives done with no sub-warp
    n_sub = 0; n_done = 0;
    load(2, '0, 0); cycle("R5 empty load");
    cycle("R5 empty done");
    check(n_sub == 0 && n_done == 1, "R5 empty mask", {n_sub[15:0], n_done[15:0]}, 32'h0000_0001);

    // R8: jump on a warp whose threads are all in flight
    n_sub = 0; n_done = 0;
    load(1, ma, 1); cycle("R8 jump load");
    cycle("R8 jump cycle");
    cycle("R8 after jump");
    check(n_sub == 1 && n_done == 1, "R8 single sub-warp", {n_sub[15:0], n_done[15:0]}, 32'h0001_0001);

    // R9: reload warp 1 without completion: held back
    n_sub = 0;
    load(1, ma, 0); cycle("R9 reload");
    repeat (3) cycle("R9 blocked");
    check(n_sub == 0 && stall_o, "R9 no sub-warp while in flight", {n_sub[15:0], 15'd0, stall_o}, 32'h0000_0001);
    // R6: load under stall ignored
    load(3, 32'h0000_000F, 0); cycle("R6 load under stall");
    check(sw_warp_o == 2'd1, "R6 warp kept", sw_warp_o, 1);
    // R10: completion releases threads one cycle later
    complete(1, 0); cycle("R10 completion edge");
    cycle("R10 released");
    drain("R9/R10 finish", 1);

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(2, 0) == 0) begin
        int w = int'($urandom_range(3, 0));
        load(w, NC'($urandom & $urandom), $urandom_range(7, 0) == 0);
      end
      if ($urandom_range(1, 0) == 1) complete(int'($urandom_range(3, 0)), 1'b1);
      cycle(model_stall() ? "R6/R9 random" : "R2/R4/R5/R8 random");
    end
    drain("R3/R10 random drain", 1);
    for (int w = 0; w < 4; w++) begin
      complete(w, 0); cycle("R10 final clear");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule